// File: doc/BRIEF.md
# Chained Byte Subtract and Compare Unit

This block is a byte-wide arithmetic unit that subtracts and compares. It builds its status flags so that a wider value, 16 or 32 bits, can be handled as a run of byte steps. The run starts at the least significant byte and ends at the most significant byte. After the last step, one conditional branch can test the outcome for the whole value. Each operation takes a register operand and either a second register operand or an immediate. It also takes the flags left by the previous step. It returns a result, a write-enable for the destination register and the new flags.

The operations that use the carry fold the zero flag of all earlier bytes into the new zero flag. A chained equality test therefore reports equality only when every byte matched. The compare operations produce the same flags as their subtract counterparts but never ask for a register write, so a wide compare leaves both operands untouched. There is no add-immediate. Adding a constant is done by subtracting its two's-complement negation with the immediate subtract operations, and the carry-using form extends this to wider constants.

All outputs are registered. An operation presented at one rising edge appears on the outputs after that edge, and a new operation may be presented every cycle.

Top module: `chain_sub_alu`

## Requirements
- R1: While `rst_n` is low, `result_o` is 0, `wr_en_o` is 0 and `flags_o` is 0.
- R2: Opcode 3'b000 gives A−B and opcode 3'b010 gives A−IMM, both modulo 256, with `wr_en_o`=1. A constant K is added by using opcode 3'b010 with IMM = −K.
- R3: Opcode 3'b001 gives A−B−C and opcode 3'b011 gives A−IMM−C, where C is `flags_i` bit 0, with `wr_en_o`=1.
- R4: Flag C (`flags_o` bit 0) is 1 exactly when the unsigned value A is less than the second operand plus the incoming carry.
- R5: Flag Z is `flags_o` bit 1. For opcodes with opcode bit 0 set (3'b001, 3'b011, 3'b101), the new Z equals (result==0) AND `flags_i` bit 1. For the other computing opcodes, the new Z equals (result==0) alone.
- R6: Flag N (`flags_o` bit 2) is result bit 7. Flag V (bit 3) is 1 when the sign bits of A and the second operand differ and the result's sign differs from A's. Flag S (bit 4) is N XOR V.
- R7: Opcodes 3'b100 (A vs B), 3'b101 (A vs B with carry) and 3'b110 (A vs IMM) give the flags of the matching subtract, with `wr_en_o`=0 and `result_o`=0.
- R8: Opcode 3'b111 copies `flags_i` to `flags_o` unchanged, with `wr_en_o`=0 and `result_o`=0.
- R9: Each operation appears on the outputs one clock after it is sampled, and an operation can be sampled on every cycle.
- R10: The chain works over four bytes. Compare on the low byte, then compare-with-carry on the three higher bytes, each step fed the previous step's flags. The final flags then give Z = (A==B), C = unsigned A<B and S = signed A<B for the 32-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| rs_a_i | input | 8 | First operand (minuend) |
| rs_b_i | input | 8 | Second register operand |
| imm_i | input | 8 | Immediate operand |
| flags_i | input | 5 | Incoming flags {S,V,N,Z,C} |
| result_o | output | 8 | Difference to write back |
| wr_en_o | output | 1 | Destination register write request |
| flags_o | output | 5 | New flags {S,V,N,Z,C} |

## Verification
Single subtractions are tried with operand pairs that are equal, that borrow and that overflow in both signed directions. These cases separate the C, Z and V rules from one another. Carry-using steps are run twice with the same operands and a different incoming Z, which shows that zero folding happens on those opcodes and not on the plain ones. Wide values are driven as true four-byte chains, with each step's flags taken from the previous output. The chains cover equal values, values that differ only in a lower byte, and a signed-versus-unsigned ordering case, and each is judged against the 32-bit outcome. A 16-bit constant addition through the immediate forms confirms the negated-constant method.

// File: rtl/chain_sub_pkg.sv
package chain_sub_pkg;

    localparam int FLAG_W = 5;

    // Flag vector layout: bit0 carry/borrow, bit1 zero, bit2 negative,
    // bit3 overflow, bit4 signed-less.
    typedef struct packed {
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    // bit0 = consumes carry, bit1 = immediate operand, bit2 = compare only
    typedef enum logic [2:0] {
        OP_SUB  = 3'b000,
        OP_SBC  = 3'b001,
        OP_SUBI = 3'b010,
        OP_SBCI = 3'b011,
        OP_CMP  = 3'b100,
        OP_CPC  = 3'b101,
        OP_CPI  = 3'b110,
        OP_HOLD = 3'b111
    } op_e;

    typedef struct packed {
        logic use_imm;
        logic use_carry;
        logic write_back;
        logic hold;
    } dec_t;

endpackage

// File: rtl/chain_op_decode.sv
module chain_op_decode
    import chain_sub_pkg::*;
(
    input  op_e  op_i,
    output dec_t dec_o
);

    always_comb begin
        dec_o = '0;
        unique case (op_i)
            OP_SUB:  begin dec_o.write_back = 1'b1; end
            OP_SBC:  begin dec_o.write_back = 1'b1; dec_o.use_carry = 1'b1; end
            OP_SUBI: begin dec_o.write_back = 1'b1; dec_o.use_imm = 1'b1; end
            OP_SBCI: begin dec_o.write_back = 1'b1; dec_o.use_imm = 1'b1;
                           dec_o.use_carry = 1'b1; end
            OP_CMP:  begin end
            OP_CPC:  begin dec_o.use_carry = 1'b1; end
            OP_CPI:  begin dec_o.use_imm = 1'b1; end
            OP_HOLD: begin dec_o.hold = 1'b1; end
            default: begin dec_o.hold = 1'b1; end
        endcase
    end

endmodule

// File: rtl/chain_sub_core.sv
module chain_sub_core #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] diff_o,
    output logic         borrow_o,
    output logic         ovf_o
);

    localparam int MSB = W - 1;

    logic [W:0] wide;

    always_comb begin
        wide     = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
        diff_o   = wide[W-1:0];
        borrow_o = wide[W];
        ovf_o    = (a_i[MSB] ^ b_i[MSB]) & (diff_o[MSB] ^ a_i[MSB]);
    end

    // No borrow means the minuend covered subtrahend plus carry
    always_comb begin
        if (!borrow_o) begin
            AST_NO_BORROW_ORDER: assert ({1'b0, a_i} >= ({1'b0, b_i} + {{W{1'b0}}, cin_i})); // R4
        end
    end

endmodule

// File: rtl/chain_flag_gen.sv
module chain_flag_gen
    import chain_sub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] diff_i,
    input  logic         borrow_i,
    input  logic         ovf_i,
    input  logic         chain_i,
    input  logic         hold_i,
    input  flags_t       prev_i,
    output flags_t       flags_o
);

    logic z_local;

    always_comb begin
        z_local = (diff_i == '0);
        if (hold_i) begin
            flags_o = prev_i;
        end else begin
            flags_o.c = borrow_i;
            flags_o.z = chain_i ? (z_local & prev_i.z) : z_local;
            flags_o.n = diff_i[W-1];
            flags_o.v = ovf_i;
            flags_o.s = diff_i[W-1] ^ ovf_i;
        end
    end

endmodule

// File: rtl/chain_sub_alu.sv
module chain_sub_alu
    import chain_sub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [W-1:0]      rs_a_i,
    input  logic [W-1:0]      rs_b_i,
    input  logic [W-1:0]      imm_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [W-1:0]      result_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] flags_o
);

    typedef struct packed {
        logic [W-1:0] result;
        logic         we;
        flags_t       flags;
    } out_t;

    op_e    op_cur;
    dec_t   dec;
    flags_t prev_flags;
    logic [W-1:0] operand_b;
    logic [W-1:0] diff;
    logic         borrow;
    logic         ovf;
    flags_t       new_flags;
    out_t         out_d;
    out_t         out_q;

    assign op_cur     = op_e'(op_i);
    assign prev_flags = flags_t'(flags_i);

    chain_op_decode u_dec (
        .op_i  (op_cur),
        .dec_o (dec)
    );

    assign operand_b = dec.use_imm ? imm_i : rs_b_i;

    chain_sub_core #(.W(W)) u_core (
        .a_i      (rs_a_i),
        .b_i      (operand_b),
        .cin_i    (dec.use_carry & prev_flags.c),
        .diff_o   (diff),
        .borrow_o (borrow),
        .ovf_o    (ovf)
    );

    chain_flag_gen #(.W(W)) u_flags (
        .diff_i   (diff),
        .borrow_i (borrow),
        .ovf_i    (ovf),
        .chain_i  (dec.use_carry),
        .hold_i   (dec.hold),
        .prev_i   (prev_flags),
        .flags_o  (new_flags)
    );

    always_comb begin
        out_d        = '0;
        out_d.flags  = new_flags;
        out_d.we     = dec.write_back;
        out_d.result = dec.write_back ? diff : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.result;
    assign wr_en_o  = out_q.we;
    assign flags_o  = out_q.flags;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (result_o == '0 && !wr_en_o && flags_o == '0)); // R1

    AST_SUB_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2] == 1'b0) |=> wr_en_o); // R2

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2] == 1'b1) |=> (!wr_en_o && result_o == '0)); // R7

    AST_CHAIN_Z_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[0] && op_i != OP_HOLD && !flags_i[1]) |=> !flags_o[1]); // R5

    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_HOLD) |=> (!flags_o[1] || !flags_o[2])); // R6

    AST_HOLD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_HOLD) |=> (flags_o == $past(flags_i) && !wr_en_o)); // R8

endmodule

// File: tb/tb_chain_sub_alu.sv
module tb_chain_sub_alu;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = 3'b111;
    logic [7:0] rs_a_i = '0;
    logic [7:0] rs_b_i = '0;
    logic [7:0] imm_i = '0;
    logic [4:0] flags_i = '0;
    logic [7:0] result_o;
    logic       wr_en_o;
    logic [4:0] flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [13:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_sub_alu dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .rs_a_i   (rs_a_i),
        .rs_b_i   (rs_b_i),
        .imm_i    (imm_i),
        .flags_i  (flags_i),
        .result_o (result_o),
        .wr_en_o  (wr_en_o),
        .flags_o  (flags_o)
    );

    // Model from the requirements: returns {result[7:0], we, flags[4:0]}
    function automatic logic [13:0] model(input logic [2:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] imm,
                                          input logic [4:0] fl);
        int opb, cin, d, sa, sb, sd;
        logic [7:0] res;
        logic c, z, n, v, s, we;
        if (op == 3'b111) return {8'h00, 1'b0, fl};
        opb = op[1] ? int'(imm) : int'(b);
        cin = op[0] ? int'(fl[0]) : 0;
        d   = int'(a) - opb - cin;
        res = d[7:0];
        c   = (d < 0);
        z   = (res == 8'h00);
        if (op[0]) z = z & fl[1];
        sa  = int'($signed(a));
        sb  = op[1] ? int'($signed(imm)) : int'($signed(b));
        sd  = sa - sb - cin;
        v   = (sd < -128) || (sd > 127);
        n   = res[7];
        s   = n ^ v;
        we  = !op[2];
        return {we ? res : 8'h00, we, s, v, n, z, c};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: apply one op at the falling edge, queue its expectation
    task automatic drive(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] imm, input logic [4:0] fl, input bit fb,
                         input string req);
        logic [4:0] f;
        @(negedge clk);
        f = fb ? flags_o : fl;
        op_i = op; rs_a_i = a; rs_b_i = b; imm_i = imm; flags_i = f;
        exp_q.push_back(model(op, a, b, imm, f));
        tag_q.push_back(req);
    endtask

    // Monitor: result due one clock after the sampling edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [13:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({result_o, wr_en_o, flags_o} == e, t,
                      {18'h0, result_o, wr_en_o, flags_o}, {18'h0, e});
            end
        end
    end

    // Four-byte compare chain with live flag feedback (R10)
    task automatic chain32(input logic [31:0] a, input logic [31:0] b);
        drive(3'b100, a[7:0], b[7:0], 8'h00, 5'b00000, 1'b0, "R10");
        for (int i = 1; i < 4; i++)
            drive(3'b101, a[8*i +: 8], b[8*i +: 8], 8'h00, 5'b00000, 1'b1, "R10");
        @(posedge clk);
        #2;
        check(flags_o[1] == (a == b), "R10_z", {31'h0, flags_o[1]}, {31'h0, a == b});
        check(flags_o[0] == (a < b), "R10_c", {31'h0, flags_o[0]}, {31'h0, a < b});
        check(flags_o[4] == ($signed(a) < $signed(b)), "R10_s", {31'h0, flags_o[4]},
              {31'h0, $signed(a) < $signed(b)});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(result_o == 8'h00 && !wr_en_o && flags_o == 5'b0, "R1",
              {18'h0, result_o, wr_en_o, flags_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 plain subtract, register and immediate
        drive(3'b000, 8'h50, 8'h20, 8'h00, 5'b00000, 1'b0, "R2");
        drive(3'b010, 8'h10, 8'h00, 8'hFB, 5'b00000, 1'b0, "R2_add_via_neg");
        // R4 borrow
        drive(3'b000, 8'h20, 8'h50, 8'h00, 5'b00000, 1'b0, "R4");
        drive(3'b010, 8'h00, 8'h00, 8'h01, 5'b00000, 1'b0, "R4");
        // R6 overflow both directions
        drive(3'b000, 8'h80, 8'h01, 8'h00, 5'b00000, 1'b0, "R6");
        drive(3'b000, 8'h7F, 8'hFF, 8'h00, 5'b00000, 1'b0, "R6");
        // R3 carry forms
        drive(3'b001, 8'h10, 8'h05, 8'h00, 5'b00001, 1'b0, "R3");
        drive(3'b011, 8'h00, 8'h00, 8'hFF, 5'b00001, 1'b0, "R3");
        // R5 zero folding vs plain zero
        drive(3'b001, 8'h05, 8'h05, 8'h00, 5'b00000, 1'b0, "R5_fold_clear");
        drive(3'b001, 8'h05, 8'h05, 8'h00, 5'b00010, 1'b0, "R5_fold_set");
        drive(3'b000, 8'h05, 8'h05, 8'h00, 5'b00000, 1'b0, "R5_plain");
        // R7 compares
        drive(3'b100, 8'h40, 8'h40, 8'h00, 5'b00000, 1'b0, "R7");
        drive(3'b101, 8'h40, 8'h41, 8'h00, 5'b00011, 1'b0, "R7");
        drive(3'b110, 8'h10, 8'h00, 8'h20, 5'b00000, 1'b0, "R7");
        // R8 hold
        drive(3'b111, 8'hAA, 8'h55, 8'h11, 5'b10110, 1'b0, "R8");
        drive(3'b111, 8'h00, 8'h00, 8'h00, 5'b01001, 1'b0, "R8");
        // R9 16-bit constant addition 0x12FF + 1 via SUBI/SBCI with feedback
        drive(3'b010, 8'hFF, 8'h00, 8'hFF, 5'b00000, 1'b0, "R9");
        drive(3'b011, 8'h12, 8'h00, 8'hFF, 5'b00000, 1'b1, "R9");
        @(posedge clk);
        #2;
        check(result_o == 8'h13, "R9_hi", {24'h0, result_o}, 32'h13);

        chain32(32'h1234_5678, 32'h1234_5678);
        chain32(32'h1234_5678, 32'h1234_5679);
        chain32(32'h1234_0078, 32'h1234_5678);
        chain32(32'hF000_0000, 32'h0000_0001);
        chain32(32'h0000_0001, 32'hF000_0000);

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule